// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block turns a stream of data bits into a line waveform in one of four codes, chosen by a 2-bit select: plain non-return-to-zero (NRZ), NRZ with inversion on ones (NRZI), return-to-zero (RZ), and Manchester. It runs from a clock at twice the bit rate, so every bit fills two clock cycles on the line. These are a leading half and a trailing half. A small phase machine tracks which half is current. RZ and Manchester change level in the middle of a bit, and a dedicated three-state machine produces the Manchester mid-bit transition.

A valid qualifier travels with the data. A bit, together with the code select, is taken only on the clock edge that starts a leading half while valid is high. The line register updates on that same edge, so the leading-half level appears one clock after the bit is presented. The trailing-half level follows on the next edge. While valid is low the encoder idles without consuming anything. The reset is active-low. It asserts asynchronously and releases through a synchronizer.

Top module: `line_encoder`

## Requirements
- R1: While the reset input is low, line_o is 0. Reset also returns the phase to the leading half and clears the stored NRZI level to 0, so the first NRZI bit 0 after reset produces 0 in both halves.
- R2: Each accepted bit occupies exactly two clock cycles. Data is sampled only on the edge that begins the leading half. A change on data_i during the trailing half has no effect on the line.
- R3: With mode_i = 00 (NRZ), both halves of the bit equal the data bit.
- R4: With mode_i = 01 (NRZI), a data 1 inverts the stored level and a data 0 keeps it, and both halves show the new level. Bits sent in other modes leave the stored level unchanged.
- R5: With mode_i = 10 (RZ), a data 1 gives 1 then 0, and a data 0 gives 0 in both halves.
- R6: With mode_i = 11 (Manchester), a data 0 gives 0 then 1, and a data 1 gives 1 then 0. Back-to-back equal bits therefore toggle the line at every half.
- R7: While valid_i is low at a bit boundary, no bit is consumed and, for modes other than NRZI, line_o is 0. The next valid bit is captured on the very next edge.
- R8: While valid_i is low with mode_i = 01, line_o holds the stored NRZI level, and that level is unchanged when traffic resumes.
- R9: The code select is sampled only at a bit boundary. A change on mode_i during the trailing half does not alter that bit's second-half level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at twice the bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Line code select: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| valid_i | input | 1 | Qualifies data_i at a bit boundary |
| data_i | input | 1 | Data bit to encode |
| line_o | output | 1 | Encoded line level, registered |

## Verification
A continuous valid stream crosses all four codes. It uses runs of equal bits and alternating bits, so that NRZ is told apart from NRZI by the history-dependent level, and RZ is told apart from Manchester by the second-half level for a data 0. An NRZI run placed after NRZ, RZ and Manchester traffic shows that the stored level survives other modes. Idle gaps in NRZI and non-NRZI modes separate hold-level behaviour from forced-low behaviour. Changes on data and mode during a trailing half confirm that sampling happens only at the boundary. A reset in the middle of traffic with the NRZI level at 1 shows that the level is cleared.

// File: rtl/le_pkg.sv
package le_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LC_NRZ   = 2'b00,
    LC_NRZI  = 2'b01,
    LC_RZ    = 2'b10,
    LC_MANCH = 2'b11
  } line_code_e;

  typedef enum logic [1:0] {
    MS_WAIT = 2'b00,
    MS_GOT0 = 2'b01,
    MS_GOT1 = 2'b10
  } manch_st_e;

  typedef enum logic {
    HALF_LEAD  = 1'b0,
    HALF_TRAIL = 1'b1
  } half_e;
endpackage

// File: rtl/le_rst_sync.sv
module le_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/le_bit_phase.sv
module le_bit_phase
  import le_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              data_i,
  output logic              take_o,
  output half_e             half_o,
  output line_code_e        mode_q_o,
  output logic              data_q_o
);
  half_e      half_q, half_d;
  line_code_e mode_q;
  logic       data_q;

  assign take_o = (half_q == HALF_LEAD) && valid_i;

  always_comb begin
    half_d = HALF_LEAD;
    if (half_q == HALF_LEAD && valid_i) half_d = HALF_TRAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= HALF_LEAD;
    else         half_q <= half_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= LC_NRZ;
      data_q <= 1'b0;
    end else if (take_o) begin
      mode_q <= line_code_e'(mode_i);
      data_q <= data_i;
    end
  end

  assign half_o   = half_q;
  assign mode_q_o = mode_q;
  assign data_q_o = data_q;

  AST_TRAIL_ENDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q == HALF_TRAIL |=> half_q == HALF_LEAD); // R2
  AST_IDLE_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q == HALF_LEAD && !valid_i) |=> half_q == HALF_LEAD); // R7
  AST_MODE_HELD_IN_TRAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q == HALF_TRAIL |=> $stable(mode_q)); // R9
endmodule

// File: rtl/le_nrzi_level.sv
module le_nrzi_level
  import le_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              data_i,
  output logic              level_o
);
  logic level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (take_i && line_code_e'(mode_i) == LC_NRZI && data_i) level_d = ~level_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;

  AST_NRZI_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(level_q)); // R8
endmodule

// File: rtl/le_manch_fsm.sv
module le_manch_fsm
  import le_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              data_i,
  output logic              lead_lvl_o,
  output logic              trail_lvl_o
);
  manch_st_e st_q, st_d;

  always_comb begin
    st_d = MS_WAIT;
    unique case (st_q)
      MS_WAIT: if (take_i && line_code_e'(mode_i) == LC_MANCH)
                 st_d = data_i ? MS_GOT1 : MS_GOT0;
      MS_GOT0: st_d = MS_WAIT;
      MS_GOT1: st_d = MS_WAIT;
      default: st_d = MS_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= MS_WAIT;
    else         st_q <= st_d;
  end

  // Waiting state: output follows the arriving bit; after a 0 emit 1, after a 1 emit 0.
  assign lead_lvl_o  = data_i;
  assign trail_lvl_o = (st_q == MS_GOT0);

  AST_MANCH_BACK_TO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != MS_WAIT |=> st_q == MS_WAIT); // R6
endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import le_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              valid_i,
  input  logic              data_i,
  output logic              line_o
);
  logic       rst_sync_n;
  logic       take;
  half_e      half;
  line_code_e mode_q;
  logic       data_q;
  logic       nrzi_lvl;
  logic       man_lead, man_trail;
  logic       line_q, line_d;

  le_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  le_bit_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .valid_i (valid_i),
    .mode_i  (mode_i),
    .data_i  (data_i),
    .take_o  (take),
    .half_o  (half),
    .mode_q_o(mode_q),
    .data_q_o(data_q)
  );

  le_nrzi_level u_nrzi (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .take_i (take),
    .mode_i (mode_i),
    .data_i (data_i),
    .level_o(nrzi_lvl)
  );

  le_manch_fsm u_manch (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .take_i     (take),
    .mode_i     (mode_i),
    .data_i     (data_i),
    .lead_lvl_o (man_lead),
    .trail_lvl_o(man_trail)
  );

  always_comb begin
    line_d = 1'b0;
    if (take) begin
      unique case (line_code_e'(mode_i))
        LC_NRZ:   line_d = data_i;
        LC_NRZI:  line_d = nrzi_lvl ^ data_i;
        LC_RZ:    line_d = data_i;
        LC_MANCH: line_d = man_lead;
        default:  line_d = 1'b0;
      endcase
    end else if (half == HALF_TRAIL) begin
      unique case (mode_q)
        LC_NRZ:   line_d = data_q;
        LC_NRZI:  line_d = nrzi_lvl;
        LC_RZ:    line_d = 1'b0;
        LC_MANCH: line_d = man_trail;
        default:  line_d = 1'b0;
      endcase
    end else if (line_code_e'(mode_i) == LC_NRZI) begin
      line_d = nrzi_lvl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) line_q <= 1'b0;
    else             line_q <= line_d;
  end

  assign line_o = line_q;

  AST_RZ_TRAIL_LOW: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (half == HALF_TRAIL && mode_q == LC_RZ) |=> line_q == 1'b0); // R5
  AST_MANCH_MID_FLIP: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (half == HALF_TRAIL && mode_q == LC_MANCH) |=> line_q != $past(line_q)); // R6
  AST_NRZ_FLAT_BIT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (half == HALF_TRAIL && mode_q == LC_NRZ) |=> line_q == $past(line_q)); // R3
  AST_NRZI_FLAT_BIT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (half == HALF_TRAIL && mode_q == LC_NRZI) |=> line_q == $past(line_q)); // R4
endmodule

// File: tb/line_encoder_bench.sv
`timescale 1ns/1ps
module line_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       valid;
  logic       data;
  logic       line;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  line_encoder u_line_encoder (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .mode_i (mode),
    .valid_i(valid),
    .data_i (data),
    .line_o (line)
  );

  // {mode[1:0], data, expected leading half, expected trailing half}
  localparam logic [4:0] VEC [18] = '{
    5'b00_1_11, 5'b00_0_00,
    5'b01_1_11, 5'b01_1_00, 5'b01_0_00, 5'b01_1_11, 5'b01_0_11,
    5'b10_1_10, 5'b10_0_00, 5'b10_1_10,
    5'b11_0_01, 5'b11_0_01, 5'b11_1_10, 5'b11_1_10, 5'b11_0_01,
    5'b00_1_11,
    5'b01_0_11, 5'b01_1_00
  };

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (line !== exp) begin
      errors++;
      $display("FAIL %s: line_o=%0b expected %0b at %0t", tag, line, exp, $time);
    end
  endtask

  // Called at a negedge; returns at a negedge after both halves are checked.
  task automatic send(input logic [1:0] m, input logic d, input logic e1, input logic e2,
                      input string tag, input logic flip_d, input logic chg_m,
                      input logic [1:0] new_m);
    mode = m; data = d; valid = 1'b1;
    @(negedge clk);
    check(tag, e1);
    if (flip_d) data = ~d;
    if (chg_m)  mode = new_m;
    @(negedge clk);
    check(tag, e2);
  endtask

  task automatic idle(input logic [1:0] m, input int n, input logic exp, input string tag);
    valid = 1'b0; mode = m;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(tag, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; valid = 1'b0; data = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Continuous stream across all codes (R3 R4 R5 R6)
    for (int i = 0; i < 18; i++)
      send(VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0], req_of(VEC[i][4:3]), 1'b0, 1'b0, 2'b00);

    // R7: idle forces low, next valid bit captured at once
    send(2'b00, 1'b1, 1'b1, 1'b1, "R3", 1'b0, 1'b0, 2'b00);
    idle(2'b00, 3, 1'b0, "R7");
    send(2'b10, 1'b1, 1'b1, 1'b0, "R7", 1'b0, 1'b0, 2'b00);

    // R8: NRZI level held while idle (level 0 -> 1)
    send(2'b01, 1'b1, 1'b1, 1'b1, "R4", 1'b0, 1'b0, 2'b00);
    idle(2'b01, 3, 1'b1, "R8");
    send(2'b01, 1'b0, 1'b1, 1'b1, "R8", 1'b0, 1'b0, 2'b00);

    // R2: data changes in the trailing half are ignored
    send(2'b00, 1'b0, 1'b0, 1'b0, "R2", 1'b1, 1'b0, 2'b00);
    send(2'b11, 1'b1, 1'b1, 1'b0, "R2", 1'b1, 1'b0, 2'b00);

    // R9: mode changes in the trailing half are ignored
    send(2'b10, 1'b1, 1'b1, 1'b0, "R9", 1'b0, 1'b1, 2'b00);
    send(2'b00, 1'b1, 1'b1, 1'b1, "R9", 1'b0, 1'b1, 2'b11);

    // R1: reset mid-traffic with line high and NRZI level 1
    rst_n = 1'b0; valid = 1'b0;
    @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    idle(2'b01, 3, 1'b0, "R1");
    send(2'b01, 1'b0, 1'b0, 1'b0, "R1", 1'b0, 1'b0, 2'b00);
    send(2'b01, 1'b1, 1'b1, 1'b1, "R4", 1'b0, 1'b0, 2'b00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule